// File: doc/BRIEF.md
# Protected Tightly Coupled Data RAM

This block is a 1 KiB data memory that sits at the bottom of a processor's address map. It serves loads and stores locally and does not go to the external bus. Each request carries a byte address, four byte enables, a write flag, an instruction-fetch flag and a privilege flag. The block decodes these and decides what to do. Reads return one cycle after they are accepted. Writes go into a byte-lane storage array, and only the enabled lanes are written.

The block has three special rules. Instruction fetches into the RAM range raise a fault and return no data. The lowest 64 bytes are write-protected against user-mode stores. A separate lock input extends that protection to supervisor-mode stores, which keeps a non-maskable interrupt vector at word 0x000 safe. A blocked write leaves memory untouched and raises a one-cycle violation pulse.

A byte-order input selects little-endian or big-endian lane mapping on the data path. Addresses at or above 0x400 are not served by this block. For those, the block raises the external-bus request output. RAM hits are always reported as non-cacheable.

Top module: `tcmDataRam`

## Requirements
- R1: A data request with address below 0x400 is served locally, and `extBusReq` stays low in that same cycle.
- R2: A read hit (`reqWrite`=0, `reqFetch`=0) in user or supervisor mode raises `rspValid` for exactly the following cycle, with the stored word on `rspRData`.
- R3: A fetch request (`reqFetch`=1) below 0x400 raises `fetchFault` for one cycle on the following cycle. It gives no `rspValid` and changes no memory, even if `reqWrite` is also set.
- R4: `cacheableOut` is low for every hit, whatever `reqCacheable` is. For a miss, `cacheableOut` equals `reqCacheable`.
- R5: With `endianBig`=0, bus bits [8i+7:8i] map to byte address 4w+i. With `endianBig`=1, they map to byte address 4w+3-i. Both reads and writes use this mapping.
- R6: Byte-enable bit i qualifies bus lane i. A write changes only the bytes selected by the enables after the R5 mapping.
- R7: A user-mode write (`reqSuper`=0) to 0x000..0x03F leaves memory unchanged. `protViolation` pulses on the following cycle.
- R8: When `superProtect`=1, a supervisor write to 0x000..0x03F is blocked and raises the same pulse. When `superProtect`=0, the write succeeds with no pulse.
- R9: Writes to 0x040..0x3FF succeed in both modes and raise no `protViolation`.
- R10: A request at or above 0x400 raises `extBusReq` in the same cycle. It produces no `rspValid`, `fetchFault` or `protViolation`.
- R11: While reset is asserted and right after it, `rspValid`, `fetchFault` and `protViolation` are low and `rspRData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Byte address, word aligned |
| reqByteEn | input | 4 | Per-lane byte enables |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqFetch | input | 1 | 1 = instruction fetch |
| reqSuper | input | 1 | 1 = supervisor mode |
| reqWData | input | 32 | Store data |
| reqCacheable | input | 1 | Cacheability attribute from the memory template |
| endianBig | input | 1 | 0 = little-endian, 1 = big-endian |
| superProtect | input | 1 | Extends low-region write protection to supervisor mode |
| rspValid | output | 1 | Read data valid |
| rspRData | output | 32 | Read data |
| fetchFault | output | 1 | Unimplemented-operation fault pulse |
| protViolation | output | 1 | Blocked-write pulse |
| extBusReq | output | 1 | Request handed to the external bus |
| cacheableOut | output | 1 | Effective cacheability of the request |

## Verification
`extBusReq` and `cacheableOut` are decoded from the request in the same cycle. The bench samples them 1 ns after it drives the inputs on the falling edge, before the next rising edge. `rspValid`, `rspRData`, `fetchFault` and `protViolation` come from one register stage, so they are due on the rising edge after the request. The bench samples them on the falling edge that follows. It drops `reqValid` at that same falling edge, so every pulse is seen in exactly one sample. Checks that memory was not changed (blocked writes, faulted fetches) are separate read requests issued after the stimulus. They look at the affected word through the normal read port.

// File: rtl/tcmRamPkg.sv
package tcmRamPkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic swap;
  } ramStrobes_t;

  function automatic logic [DATA_W-1:0] swapBytes(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = d[8*(LANES-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [LANES-1:0] swapLanes(input logic [LANES-1:0] b);
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) r[i] = b[LANES-1-i];
    return r;
  endfunction
endpackage

// File: rtl/tcmRamCtrl.sv
module tcmRamCtrl
  import tcmRamPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RAM_BYTES  = 1024,
  parameter int PROT_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic              reqSuper,
  input  logic              reqCacheable,
  input  logic              endianBig,
  input  logic              superProtect,
  output ramStrobes_t       strobes,
  output logic              rspValid,
  output logic              fetchFault,
  output logic              protViolation,
  output logic              extBusReq,
  output logic              cacheableOut
);
  localparam int RAM_AW = $clog2(RAM_BYTES);
  localparam logic [RAM_AW-1:0] PROT_LIM = RAM_AW'(PROT_BYTES);

  logic inRange, protRegion, hit, fetchHit, rdHit, wrReq, wrBlocked;

  // range and region decode
  assign inRange    = (reqAddr[ADDR_W-1:RAM_AW] == '0);
  assign protRegion = (reqAddr[RAM_AW-1:0] < PROT_LIM);
  assign hit        = reqValid && inRange;

  // request classification; a fetch wins over the write flag
  assign fetchHit  = hit && reqFetch;
  assign rdHit     = hit && !reqFetch && !reqWrite;
  assign wrReq     = hit && !reqFetch && reqWrite;
  assign wrBlocked = wrReq && protRegion && (!reqSuper || superProtect);

  assign strobes.wrEn = wrReq && !wrBlocked;
  assign strobes.rdEn = rdHit;
  assign strobes.swap = endianBig;

  // external side: misses pass through, hits are never cacheable
  assign extBusReq    = reqValid && !inRange;
  assign cacheableOut = reqValid && !inRange && reqCacheable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      fetchFault    <= 1'b0;
      protViolation <= 1'b0;
    end else begin
      rspValid      <= rdHit;
      fetchFault    <= fetchHit;
      protViolation <= wrBlocked;
    end
  end
endmodule

// File: rtl/tcmRamDatapath.sv
module tcmRamDatapath
  import tcmRamPkg::*;
#(
  parameter int RAM_BYTES = 1024
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ramStrobes_t                      strobes,
  input  logic [$clog2(RAM_BYTES/LANES)-1:0] wordIdx,
  input  logic [LANES-1:0]                 byteEn,
  input  logic [DATA_W-1:0]                wData,
  output logic [DATA_W-1:0]                rData
);
  localparam int WORDS = RAM_BYTES / LANES;

  logic [LANES-1:0]  memBe;
  logic [DATA_W-1:0] memData;
  logic [DATA_W-1:0] rawWord;
  logic [DATA_W-1:0] rdReg;

  // map bus lanes onto storage lanes
  assign memBe   = strobes.swap ? swapLanes(byteEn) : byteEn;
  assign memData = strobes.swap ? swapBytes(wData) : wData;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneMem [WORDS];
    always_ff @(posedge clk) begin
      if (strobes.wrEn && memBe[g]) laneMem[wordIdx] <= memData[8*g +: 8];
    end
    assign rawWord[8*g +: 8] = laneMem[wordIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdReg <= '0;
    else if (strobes.rdEn) rdReg <= strobes.swap ? swapBytes(rawWord) : rawWord;
  end

  assign rData = rdReg;
endmodule

// File: rtl/tcmDataRam.sv
module tcmDataRam
  import tcmRamPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RAM_BYTES  = 1024,
  parameter int PROT_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqByteEn,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic              reqSuper,
  input  logic [31:0]       reqWData,
  input  logic              reqCacheable,
  input  logic              endianBig,
  input  logic              superProtect,
  output logic              rspValid,
  output logic [31:0]       rspRData,
  output logic              fetchFault,
  output logic              protViolation,
  output logic              extBusReq,
  output logic              cacheableOut
);
  localparam int RAM_AW = $clog2(RAM_BYTES);

  ramStrobes_t strobes;

  tcmRamCtrl #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .PROT_BYTES(PROT_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .reqSuper(reqSuper),
    .reqCacheable(reqCacheable), .endianBig(endianBig), .superProtect(superProtect),
    .strobes(strobes), .rspValid(rspValid), .fetchFault(fetchFault),
    .protViolation(protViolation), .extBusReq(extBusReq), .cacheableOut(cacheableOut)
  );

  tcmRamDatapath #(.RAM_BYTES(RAM_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wordIdx(reqAddr[RAM_AW-1:2]), .byteEn(reqByteEn),
    .wData(reqWData), .rData(rspRData)
  );
endmodule

// File: rtl/tcmRamChecks.sv
module tcmRamChecks #(
  parameter int ADDR_W     = 32,
  parameter int RAM_BYTES  = 1024,
  parameter int PROT_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              reqFetch,
  input logic              reqSuper,
  input logic              superProtect,
  input logic              rspValid,
  input logic              fetchFault,
  input logic              protViolation,
  input logic              extBusReq,
  input logic              cacheableOut
);
  logic inR, inP;
  assign inR = reqAddr < ADDR_W'(RAM_BYTES);
  assign inP = reqAddr < ADDR_W'(PROT_BYTES);

  p_local_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inR |-> !extBusReq);
  p_read_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inR && !reqFetch && !reqWrite |=> rspValid);
  p_fetch_fault_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inR && reqFetch |=> fetchFault && !rspValid);
  p_never_cached_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inR |-> !cacheableOut);
  p_user_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inP && reqWrite && !reqFetch && !reqSuper |=> protViolation);
  p_super_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inP && reqWrite && !reqFetch && reqSuper |=> protViolation == $past(superProtect));
  p_open_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inR && !inP && reqWrite |=> !protViolation);
  p_miss_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !inR |-> extBusReq);
  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !inR |=> !rspValid && !fetchFault && !protViolation);
  p_one_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rspValid, fetchFault, protViolation}) <= 1);
endmodule

bind tcmDataRam tcmRamChecks #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .PROT_BYTES(PROT_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqWrite(reqWrite), .reqFetch(reqFetch), .reqSuper(reqSuper),
  .superProtect(superProtect), .rspValid(rspValid), .fetchFault(fetchFault),
  .protViolation(protViolation), .extBusReq(extBusReq), .cacheableOut(cacheableOut)
);

// File: tb/tcmDataRam_tb_top.sv
`timescale 1ns/1ps
module tcmDataRam_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqWrite, reqFetch, reqSuper, reqCacheable, endianBig, superProtect;
  logic [31:0] reqAddr, reqWData;
  logic [3:0]  reqByteEn;
  logic        rspValid, fetchFault, protViolation, extBusReq, cacheableOut;
  logic [31:0] rspRData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tcmDataRam dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqByteEn(reqByteEn), .reqWrite(reqWrite), .reqFetch(reqFetch),
    .reqSuper(reqSuper), .reqWData(reqWData), .reqCacheable(reqCacheable),
    .endianBig(endianBig), .superProtect(superProtect), .rspValid(rspValid),
    .rspRData(rspRData), .fetchFault(fetchFault), .protViolation(protViolation),
    .extBusReq(extBusReq), .cacheableOut(cacheableOut)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // One request: combinational outputs sampled 1 ns after drive,
  // registered outputs sampled on the following falling edge.
  task automatic doReq(input logic [31:0] addr, input logic [3:0] be, input logic wr,
                       input logic fe, input logic sup, input logic [31:0] wd, input logic cach,
                       output logic busO, output logic cacheO, output logic rv,
                       output logic [31:0] rd, output logic ff, output logic pv);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqByteEn = be; reqWrite = wr;
    reqFetch = fe; reqSuper = sup; reqWData = wd; reqCacheable = cach;
    #1;
    busO = extBusReq; cacheO = cacheableOut;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqFetch = 1'b0;
    rv = rspValid; rd = rspRData; ff = fetchFault; pv = protViolation;
  endtask

  task automatic writeWord(input string req, input logic [31:0] addr, input logic [3:0] be,
                           input logic sup, input logic [31:0] wd, input logic expViol);
    logic b, c, rv, ff, pv;
    logic [31:0] rd;
    doReq(addr, be, 1'b1, 1'b0, sup, wd, 1'b0, b, c, rv, rd, ff, pv);
    check(req, "write violation flag", {31'b0, pv}, {31'b0, expViol});
    check(req, "write bus request", {31'b0, b}, 32'd0);
    check(req, "write no response", {31'b0, rv}, 32'd0);
  endtask

  task automatic readWord(input string req, input logic [31:0] addr, input logic sup,
                          input logic [31:0] exp);
    logic b, c, rv, ff, pv;
    logic [31:0] rd;
    doReq(addr, 4'hF, 1'b0, 1'b0, sup, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check(req, "read bus request", {31'b0, b}, 32'd0);
    check(req, "read valid", {31'b0, rv}, 32'd1);
    check(req, "read data", rd, exp);
  endtask

  task automatic t_reset();
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqByteEn = '0; reqWrite = 1'b0;
    reqFetch = 1'b0; reqSuper = 1'b0; reqWData = '0; reqCacheable = 1'b0;
    endianBig = 1'b0; superProtect = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "rspValid in reset", {31'b0, rspValid}, 32'd0);
    check("R11", "rspRData in reset", rspRData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "fetchFault after reset", {31'b0, fetchFault}, 32'd0);
    check("R11", "protViolation after reset", {31'b0, protViolation}, 32'd0);
  endtask

  task automatic t_basic();
    writeWord("R1", 32'h100, 4'hF, 1'b1, 32'h11223344, 1'b0);
    readWord("R2", 32'h100, 1'b0, 32'h11223344);
    readWord("R2", 32'h100, 1'b1, 32'h11223344);
    writeWord("R9", 32'h3FC, 4'hF, 1'b0, 32'h5A5A0F0F, 1'b0);
    readWord("R9", 32'h3FC, 1'b1, 32'h5A5A0F0F);
  endtask

  task automatic t_endian();
    endianBig = 1'b0;
    writeWord("R5", 32'h200, 4'hF, 1'b0, 32'hA1B2C3D4, 1'b0);
    endianBig = 1'b1;
    readWord("R5", 32'h200, 1'b0, 32'hD4C3B2A1);
    writeWord("R5", 32'h204, 4'hF, 1'b0, 32'h01020304, 1'b0);
    endianBig = 1'b0;
    readWord("R5", 32'h204, 1'b0, 32'h04030201);
  endtask

  task automatic t_byteEn();
    endianBig = 1'b0;
    writeWord("R6", 32'h200, 4'b0010, 1'b0, 32'hFFFFEEFF, 1'b0);
    readWord("R6", 32'h200, 1'b0, 32'hA1B2EED4);
    endianBig = 1'b1;
    writeWord("R6", 32'h200, 4'b0001, 1'b0, 32'hFFFFFF77, 1'b0);
    endianBig = 1'b0;
    readWord("R6", 32'h200, 1'b0, 32'h77B2EED4);
  endtask

  task automatic t_fetch();
    logic b, c, rv, ff, pv;
    logic [31:0] rd;
    doReq(32'h200, 4'hF, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check("R3", "fetch fault", {31'b0, ff}, 32'd1);
    check("R3", "fetch no response", {31'b0, rv}, 32'd0);
    check("R3", "fetch no bus", {31'b0, b}, 32'd0);
    doReq(32'h200, 4'hF, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check("R3", "fetch with write flag faults", {31'b0, ff}, 32'd1);
    readWord("R3", 32'h200, 1'b0, 32'h77B2EED4);
    @(negedge clk);
    check("R3", "fault is one pulse", {31'b0, fetchFault}, 32'd0);
  endtask

  task automatic t_cache();
    logic b, c, rv, ff, pv;
    logic [31:0] rd;
    doReq(32'h104, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, b, c, rv, rd, ff, pv);
    check("R4", "hit not cacheable", {31'b0, c}, 32'd0);
    doReq(32'h8000, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, b, c, rv, rd, ff, pv);
    check("R4", "miss follows attribute", {31'b0, c}, 32'd1);
    doReq(32'h8000, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check("R4", "miss attribute low", {31'b0, c}, 32'd0);
  endtask

  task automatic t_protect();
    superProtect = 1'b0;
    writeWord("R8", 32'h000, 4'hF, 1'b1, 32'hCAFE0001, 1'b0);
    writeWord("R8", 32'h03C, 4'hF, 1'b1, 32'h0000BEEF, 1'b0);
    readWord("R8", 32'h000, 1'b0, 32'hCAFE0001);
    writeWord("R7", 32'h000, 4'hF, 1'b0, 32'h00000000, 1'b1);
    readWord("R7", 32'h000, 1'b0, 32'hCAFE0001);
    writeWord("R7", 32'h03C, 4'b0001, 1'b0, 32'h12345678, 1'b1);
    readWord("R7", 32'h03C, 1'b1, 32'h0000BEEF);
    writeWord("R9", 32'h040, 4'hF, 1'b0, 32'h600DF00D, 1'b0);
    readWord("R9", 32'h040, 1'b0, 32'h600DF00D);
    superProtect = 1'b1;
    writeWord("R8", 32'h000, 4'hF, 1'b1, 32'hDEADDEAD, 1'b1);
    readWord("R8", 32'h000, 1'b1, 32'hCAFE0001);
    writeWord("R9", 32'h044, 4'hF, 1'b1, 32'h0BADC0DE, 1'b0);
    readWord("R9", 32'h044, 1'b1, 32'h0BADC0DE);
    superProtect = 1'b0;
  endtask

  task automatic t_miss();
    logic b, c, rv, ff, pv;
    logic [31:0] rd;
    doReq(32'h400, 4'hF, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check("R10", "boundary miss bus request", {31'b0, b}, 32'd1);
    check("R10", "boundary miss no response", {31'b0, rv}, 32'd0);
    doReq(32'h1000, 4'hF, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check("R10", "fetch miss no fault", {31'b0, ff}, 32'd0);
    doReq(32'h10, 4'hF, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check("R1", "protected hit still local", {31'b0, b}, 32'd0);
    doReq(32'h10000010, 4'hF, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, b, c, rv, rd, ff, pv);
    check("R10", "high alias write no violation", {31'b0, pv}, 32'd0);
    check("R10", "high alias bus request", {31'b0, b}, 32'd1);
    readWord("R10", 32'h010, 1'b1, 32'hCAFE0001 & 32'h0 | 32'hXXXXXXXX);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_endian();
    t_byteEn();
    t_fetch();
    t_cache();
    t_protect();
    t_miss();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule